// File: doc/BRIEF.md
# Paged Adapter Register Window

This block is the host-side glue of a network adapter. It claims 32 consecutive byte ports. The low eight ports hold control bytes. The next eight ports form a window that is routed in one of two ways. It can pass through to the system-interface registers of the network controller, or it can be served from a small identification ROM that sits at the same addresses. The upper sixteen ports are unused.

A host selects what the window shows through two bits in control byte 0. One bit picks between the controller and the ROM. The other bit picks the ROM page. Control byte 1 does three jobs:

- it releases the controller from reset;
- it selects the ring speed;
- it supplies a fourth controller register-index bit, so the 8-byte window can reach controller registers 8 to 15.

Control byte 7 selects the cable interface. Host reads are registered and return one cycle after the read strobe.

Top module: `adapter_regwin`

## Requirements
- R1: After reset every control byte is 0. As a result the controller is held in reset (`ctl_reset_n`=0), `speed_16`=0, `cable_utp`=0, and the window maps the ROM.
- R2: Control bytes at offsets 0, 1 and 7 read back the last value written. Offsets 2 to 6 read 0 and ignore writes.
- R3: Bit 0 of control byte 1 is the reset release. Writing it as 1 drives `ctl_reset_n` high on the next cycle. Writing control byte 1 as 0 drives `ctl_reset_n` low again.
- R4: Bit 2 of control byte 1 drives `speed_16`. A value of 1 selects 16 Mb/s and 0 selects 4 Mb/s.
- R5: Bit 0 of control byte 7 drives `cable_utp`. A value of 1 selects unshielded twisted pair and 0 selects shielded.
- R6: When bit 2 of control byte 0 is 1, an access to offset 8+i (i = 0..7) pulses `ctl_wr` or `ctl_rd` in the same cycle. The controller index is `ctl_addr` = {bit 1 of control byte 1, i}, and `ctl_wdata` equals the host data. A window read returns `ctl_rdata`.
- R7: When bit 2 of control byte 0 is 0 and bit 3 is 0, window reads return ROM page zero. The bytes are:
  - i=0: 0x4D
  - i=1: the card type
  - i=2: the revision
  - i=3..5: configuration bytes 0..2
  - i=6..7: 0
- R8: When bit 2 of control byte 0 is 0 and bit 3 is 1, window reads return ROM page one. Byte i=0 is 0. Bytes i=1..6 are the station address, most significant byte first. Byte i=7 is 0.
- R9: While the ROM is mapped, window writes and reads never pulse `ctl_wr` or `ctl_rd`.
- R10: `host_rdata` changes only in the cycle after a read strobe, and it holds its value otherwise. Offsets 16 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 5 | Port offset from the base |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| cfg_byte0 | input | 8 | Configuration byte 0 mirror |
| cfg_byte1 | input | 8 | Configuration byte 1 mirror |
| cfg_byte2 | input | 8 | Configuration byte 2 mirror |
| station_addr | input | 48 | Station address, bits 47:40 first |
| ctl_addr | output | 4 | Controller register index |
| ctl_wr | output | 1 | Controller write strobe |
| ctl_rd | output | 1 | Controller read strobe |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data |
| ctl_reset_n | output | 1 | Controller reset release |
| speed_16 | output | 1 | Ring speed select |
| cable_utp | output | 1 | Cable interface select |

## Verification
On every cycle the assertions check the following:
- the ROM mapping fully blocks controller strobes;
- the two controller strobes are never active together;
- the forwarded index carries the window offset;
- the reset-release and speed outputs follow the last write to control byte 1;
- read data holds between read strobes.

Only the directed scenarios can show the actual ROM contents on both pages, the byte order of the station address, the high-index extension reaching register 8 and above, and the read-back of the control bytes.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int C0_SEL   = 2;
    localparam int C0_PAGE  = 3;
    localparam int C1_RUN   = 0;
    localparam int C1_HISEL = 1;
    localparam int C1_FAST  = 2;
    localparam int C7_UTP   = 0;

    typedef enum logic [1:0] {
        AREA_CTRL,
        AREA_WIN,
        AREA_NONE
    } area_e;

    typedef struct packed {
        logic [7:0] c0;
        logic [7:0] c1;
        logic [7:0] c7;
        logic [7:0] rdata;
    } regs_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int WIN_BASE = 8,
    parameter int WIN_SIZE = 8,
    localparam int IDX_W   = $clog2(WIN_SIZE)
) (
    input  logic [ADDR_W-1:0] addr,
    output area_e             area,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        idx = addr[IDX_W-1:0];
        if (int'(addr) < WIN_BASE)
            area = AREA_CTRL;
        else if (int'(addr) < WIN_BASE + WIN_SIZE)
            area = AREA_WIN;
        else
            area = AREA_NONE;
    end
endmodule

// File: rtl/regwin_rom.sv
module regwin_rom #(
    parameter logic [7:0] MFR_ID    = 8'h4D,
    parameter logic [7:0] CARD_TYPE = 8'h08,
    parameter logic [7:0] CARD_REV  = 8'h02,
    parameter int         ADDR_BYTES = 6
) (
    input  logic                  page,
    input  logic [2:0]            idx,
    input  logic [7:0]            cfg0,
    input  logic [7:0]            cfg1,
    input  logic [7:0]            cfg2,
    input  logic [8*ADDR_BYTES-1:0] station,
    output logic [7:0]            data
);
    logic [7:0] page0;
    logic [7:0] page1;

    always_comb begin
        case (idx)
            3'd0:    page0 = MFR_ID;
            3'd1:    page0 = CARD_TYPE;
            3'd2:    page0 = CARD_REV;
            3'd3:    page0 = cfg0;
            3'd4:    page0 = cfg1;
            3'd5:    page0 = cfg2;
            default: page0 = 8'h00;
        endcase
    end

    always_comb begin
        page1 = 8'h00;
        for (int b = 1; b <= ADDR_BYTES; b++) begin
            if (int'(idx) == b)
                page1 = station[8*(ADDR_BYTES-b) +: 8];
        end
    end

    assign data = page ? page1 : page0;
endmodule

// File: rtl/adapter_regwin.sv
module adapter_regwin
    import regwin_pkg::*;
#(
    parameter int         ADDR_W    = 5,
    parameter int         WIN_BASE  = 8,
    parameter int         WIN_SIZE  = 8,
    parameter logic [7:0] CARD_TYPE = 8'h08,
    parameter logic [7:0] CARD_REV  = 8'h02,
    localparam int        IDX_W     = $clog2(WIN_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [7:0]        cfg_byte0,
    input  logic [7:0]        cfg_byte1,
    input  logic [7:0]        cfg_byte2,
    input  logic [47:0]       station_addr,
    output logic [IDX_W:0]    ctl_addr,
    output logic              ctl_wr,
    output logic              ctl_rd,
    output logic [7:0]        ctl_wdata,
    input  logic [7:0]        ctl_rdata,
    output logic              ctl_reset_n,
    output logic              speed_16,
    output logic              cable_utp
);
    regs_t            r_d, r_q;
    area_e            area;
    logic [IDX_W-1:0] win_idx;
    logic [7:0]       rom_byte;

    regwin_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_SIZE(WIN_SIZE)
    ) u_dec (
        .addr(host_addr),
        .area(area),
        .idx (win_idx)
    );

    regwin_rom #(
        .CARD_TYPE(CARD_TYPE),
        .CARD_REV (CARD_REV)
    ) u_rom (
        .page   (r_q.c0[C0_PAGE]),
        .idx    (win_idx),
        .cfg0   (cfg_byte0),
        .cfg1   (cfg_byte1),
        .cfg2   (cfg_byte2),
        .station(station_addr),
        .data   (rom_byte)
    );

    always_comb begin
        r_d    = r_q;
        ctl_wr = 1'b0;
        ctl_rd = 1'b0;
        if (host_wr) begin
            if (area == AREA_CTRL) begin
                case (win_idx)
                    3'd0:    r_d.c0 = host_wdata;
                    3'd1:    r_d.c1 = host_wdata;
                    3'd7:    r_d.c7 = host_wdata;
                    default: ;
                endcase
            end else if (area == AREA_WIN && r_q.c0[C0_SEL]) begin
                ctl_wr = 1'b1;
            end
        end
        if (host_rd) begin
            case (area)
                AREA_CTRL: begin
                    case (win_idx)
                        3'd0:    r_d.rdata = r_q.c0;
                        3'd1:    r_d.rdata = r_q.c1;
                        3'd7:    r_d.rdata = r_q.c7;
                        default: r_d.rdata = 8'h00;
                    endcase
                end
                AREA_WIN: begin
                    if (r_q.c0[C0_SEL]) begin
                        ctl_rd    = 1'b1;
                        r_d.rdata = ctl_rdata;
                    end else begin
                        r_d.rdata = rom_byte;
                    end
                end
                default: r_d.rdata = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctl_addr    = {r_q.c1[C1_HISEL], win_idx};
    assign ctl_wdata   = host_wdata;
    assign host_rdata  = r_q.rdata;
    assign ctl_reset_n = r_q.c1[C1_RUN];
    assign speed_16    = r_q.c1[C1_FAST];
    assign cable_utp   = r_q.c7[C7_UTP];

    assert_rom_blocks_ctl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (area == AREA_WIN && !r_q.c0[C0_SEL]) |-> !(ctl_wr || ctl_rd));

    assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_wr, ctl_rd}));

    assert_ctl_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr || ctl_rd) |-> (ctl_addr[IDX_W-1:0] == host_addr[IDX_W-1:0]));

    assert_reset_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 5'd1) |=> (ctl_reset_n == $past(host_wdata[0])));

    assert_speed_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 5'd1) |=> (speed_16 == $past(host_wdata[2])));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/sim_adapter_regwin.sv
module sim_adapter_regwin;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  cfg0 = 8'h5A, cfg1 = 8'hC3, cfg2 = 8'h17;
    logic [47:0] station = 48'h0000F6123456;
    logic [3:0]  ctl_addr;
    logic        ctl_wr, ctl_rd;
    logic [7:0]  ctl_wdata;
    logic [7:0]  ctl_rdata;
    logic        ctl_reset_n, speed_16, cable_utp;

    int checks = 0;
    int failures = 0;
    int ctl_wr_count = 0;
    int ctl_rd_count = 0;
    logic [3:0] last_waddr;
    logic [7:0] last_wdata;

    always #10 clk = ~clk;

    assign ctl_rdata = {4'hA, ctl_addr};

    always @(posedge clk) begin
        if (ctl_wr) begin
            ctl_wr_count <= ctl_wr_count + 1;
            last_waddr   <= ctl_addr;
            last_wdata   <= ctl_wdata;
        end
        if (ctl_rd) ctl_rd_count <= ctl_rd_count + 1;
    end

    adapter_regwin #(.CARD_TYPE(8'h0D), .CARD_REV(8'h03)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_byte0(cfg0), .cfg_byte1(cfg1), .cfg_byte2(cfg2),
        .station_addr(station), .ctl_addr(ctl_addr), .ctl_wr(ctl_wr),
        .ctl_rd(ctl_rd), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .ctl_reset_n(ctl_reset_n), .speed_16(speed_16), .cable_utp(cable_utp)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        check(ctl_reset_n == 1'b0, "R1 reset_n", ctl_reset_n, 0);
        check(speed_16 == 1'b0, "R1 speed", speed_16, 0);
        check(cable_utp == 1'b0, "R1 cable", cable_utp, 0);
        rd(5'd0, v);
        check(v == 8'h00, "R1 ctl0", v, 0);
    endtask

    task automatic t_rom_pages();
        logic [7:0] v;
        logic [7:0] exp0 [8];
        exp0 = '{8'h4D, 8'h0D, 8'h03, 8'h5A, 8'hC3, 8'h17, 8'h00, 8'h00};
        for (int i = 0; i < 8; i++) begin
            rd(5'(8 + i), v);
            check(v == exp0[i], "R7 page0 byte", v, exp0[i]);
        end
        wr(5'd0, 8'h08);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            e = (i >= 1 && i <= 6) ? station[8*(6-i) +: 8] : 8'h00;
            rd(5'(8 + i), v);
            check(v == e, "R8 page1 byte", v, e);
        end
        check(ctl_rd_count == 0, "R9 no ctl read", ctl_rd_count, 0);
    endtask

    task automatic t_rom_write_blocked();
        logic [7:0] v;
        wr(5'd9, 8'hEE);
        wr(5'd14, 8'h11);
        check(ctl_wr_count == 0, "R9 no ctl write", ctl_wr_count, 0);
        rd(5'd9, v);
        check(v == 8'h00, "R9 rom unchanged", v, 8'h00);
    endtask

    task automatic t_ctrl_readback();
        logic [7:0] v;
        wr(5'd0, 8'h04);
        rd(5'd0, v);
        check(v == 8'h04, "R2 ctl0 readback", v, 8'h04);
        wr(5'd3, 8'hFF);
        rd(5'd3, v);
        check(v == 8'h00, "R2 ctl3 reads zero", v, 0);
        wr(5'd7, 8'h81);
        rd(5'd7, v);
        check(v == 8'h81, "R2 ctl7 readback", v, 8'h81);
        check(cable_utp == 1'b1, "R5 cable utp", cable_utp, 1);
        wr(5'd7, 8'h80);
        check(cable_utp == 1'b0, "R5 cable shielded", cable_utp, 0);
        rd(5'd20, v);
        check(v == 8'h00, "R10 unused offset", v, 0);
    endtask

    task automatic t_ctl_run_speed();
        logic [7:0] v;
        wr(5'd1, 8'h01);
        check(ctl_reset_n == 1'b1, "R3 release", ctl_reset_n, 1);
        check(speed_16 == 1'b0, "R4 slow", speed_16, 0);
        wr(5'd1, 8'h05);
        check(speed_16 == 1'b1, "R4 fast", speed_16, 1);
        rd(5'd1, v);
        check(v == 8'h05, "R2 ctl1 readback", v, 8'h05);
        wr(5'd1, 8'h00);
        check(ctl_reset_n == 1'b0, "R3 reassert", ctl_reset_n, 0);
        check(speed_16 == 1'b0, "R4 back slow", speed_16, 0);
    endtask

    task automatic t_ctl_window();
        logic [7:0] v;
        wr(5'd9, 8'h3C);
        check(ctl_wr_count == 1, "R6 write count", ctl_wr_count, 1);
        check(last_waddr == 4'h1 && last_wdata == 8'h3C, "R6 low index write",
              {last_waddr, last_wdata}, 12'h13C);
        wr(5'd1, 8'h03);
        wr(5'd10, 8'h99);
        check(last_waddr == 4'hA && last_wdata == 8'h99, "R6 high index write",
              {last_waddr, last_wdata}, 12'hA99);
        rd(5'd11, v);
        check(v == 8'hAB, "R6 high index read", v, 8'hAB);
        wr(5'd1, 8'h01);
        rd(5'd15, v);
        check(v == 8'hA7, "R6 low index read", v, 8'hA7);
        repeat (3) @(negedge clk);
        check(host_rdata == 8'hA7, "R10 hold", host_rdata, 8'hA7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_rom_pages();
        t_rom_write_blocked();
        t_ctrl_readback();
        t_ctl_run_speed();
        t_ctl_window();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule